// File: doc/BRIEF.md
# Hexadecimal Matrix Keypad Scanner

This block reads a sixteen-key pad wired as four row lines and four column lines. It drives the row lines active-low and reads the column lines, which sit high through pull-ups when no key is pressed. A pressed key pulls its column low only while its own row is driven low. The column inputs first pass through a synchronizer.

The scanner works through a fixed sequence of stages. First it holds every row low until the pad is fully released, waits one debounce interval and checks again. Next it waits for a closure, waits one debounce interval and checks that the closure is still there. It then drives one row low at a time to find the key. The key's position becomes a hexadecimal digit. The block presents that digit as an ASCII character, marked by a single-cycle valid strobe, and then goes back to waiting for release.

A parameter sets the debounce interval in clock cycles. A second parameter sets the depth of the column synchronizer.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is held and in the first cycle after it, `row_n_o` is 4'b0000, `key_valid_o` is 0 and `key_code_o` is 8'h00.
- R2: A key held down from reset onward produces no code. A code is produced only after the pad has read fully open (columns 4'b1111) and still reads open one debounce interval later.
- R3: A closure that has gone again (columns back to 4'b1111) when the debounce interval ends produces no code, and the scanner goes back to waiting for a closure.
- R4: `row_n_o` only ever shows 4'b0000 (all rows driven) or one of the scan patterns 4'b1110, 4'b1101, 4'b1011 and 4'b0111. The scan starts at 4'b1110 (row 0) and moves the zero one bit position toward the MSB for each row where no column is low.
- R5: A key at row r, column c (both 0 to 3, with bit r of `row_n_o` driving row r and bit c of `col_n_i` reading column c) has index 4*r + c. Indices 0 to 9 give codes 8'h30 to 8'h39, and indices 10 to 15 give codes 8'h41 to 8'h46.
- R6: When several columns read low in the scanned row, the lowest-numbered low column sets the column number.
- R7: `key_valid_o` is high for exactly one clock cycle per detected key, and `key_code_o` holds the code during that cycle.
- R8: After a code is produced, the scanner waits for full release. A key that stays held produces no further code.
- R9: If all four rows are scanned and no column is low, no code is produced and the scanner goes back to waiting for a closure. The next closure is then decoded without first needing a release.
- R10: When keys in two different rows are held, the key in the lower-numbered row is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n_o | output | 4 | Active-low row drive, registered |
| col_n_i | input | 4 | Column sense, low when a key in a driven row is pressed |
| key_valid_o | output | 1 | One-cycle strobe marking a new key code |
| key_code_o | output | 8 | ASCII character of the detected key |

## Verification
Some properties are checked on every cycle. The row drive must always be all-zero or a single zero. The valid strobe must never last two cycles. Every strobed code must lie in one of the two ASCII digit ranges. The cycle after a code is emitted must put the scanner back into release-waiting with all rows driven. Other behaviours only the bench scenarios can show. These are the correct character for each of the sixteen keys, the rejection of bounces shorter than the debounce interval, priority between keys held at the same time, the silence while a key is held, and a scan that finds nothing once the key has been let go.

// File: rtl/kp_pkg.sv
package kp_pkg;

  localparam int KP_ROWS  = 4;
  localparam int KP_COLS  = 4;
  localparam int KP_KEYS  = KP_ROWS * KP_COLS;
  localparam int KP_IDX_W = $clog2(KP_KEYS);
  localparam int KP_RIDX_W = $clog2(KP_ROWS);
  localparam int KP_CIDX_W = $clog2(KP_COLS);

  typedef enum logic [2:0] {
    ST_OPEN_WAIT,
    ST_OPEN_DB,
    ST_CLOSE_WAIT,
    ST_CLOSE_DB,
    ST_SCAN,
    ST_EMIT
  } kp_state_e;

  // lowest column position that reads low
  function automatic logic [KP_CIDX_W-1:0] lowest_low(input logic [KP_COLS-1:0] c);
    logic [KP_CIDX_W-1:0] pos;
    pos = '0;
    for (int i = KP_COLS - 1; i >= 0; i--) begin
      if (!c[i]) pos = KP_CIDX_W'(i);
    end
    return pos;
  endfunction

  // hexadecimal digit to ASCII character
  function automatic logic [7:0] hex_char(input logic [KP_IDX_W-1:0] idx);
    logic [7:0] wide;
    wide = 8'(idx);
    return (wide < 8'd10) ? (8'h30 + wide) : (8'h37 + wide);
  endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/kp_timer.sv
module kp_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] val_i,
  output logic             done_o
);

  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load_i)        cnt <= val_i;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt == '0) |=> (cnt == '0)); // R3

endmodule

// File: rtl/kp_fsm.sv
module kp_fsm
  import kp_pkg::*;
#(
  parameter int DB_CYCLES     = 1000,
  parameter int SETTLE_CYCLES = 3,
  parameter int TW            = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [KP_COLS-1:0]   cols_i,
  input  logic                 tmr_done_i,
  output logic                 tmr_load_o,
  output logic [TW-1:0]        tmr_val_o,
  output logic [KP_ROWS-1:0]   rows_n_o,
  output logic                 fire_o,
  output logic [KP_IDX_W-1:0]  idx_o
);

  localparam logic [TW-1:0] DB_VAL     = TW'(DB_CYCLES);
  localparam logic [TW-1:0] SETTLE_VAL = TW'(SETTLE_CYCLES);
  localparam logic [KP_ROWS-1:0] FIRST_ROW = ~KP_ROWS'(1);

  kp_state_e               state, nxt;
  logic [KP_ROWS-1:0]      rows_q, rows_nxt;
  logic [KP_RIDX_W-1:0]    ridx_q, ridx_nxt;
  logic [KP_IDX_W-1:0]     idx_q, idx_nxt;
  logic                    fire_q, fire_nxt;
  logic                    all_open;

  assign all_open = &cols_i;

  always_comb begin
    nxt        = state;
    rows_nxt   = rows_q;
    ridx_nxt   = ridx_q;
    idx_nxt    = idx_q;
    fire_nxt   = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = DB_VAL;
    case (state)
      ST_OPEN_WAIT: begin
        rows_nxt = '0;
        if (all_open) begin
          tmr_load_o = 1'b1;
          nxt        = ST_OPEN_DB;
        end
      end
      ST_OPEN_DB: begin
        if (tmr_done_i) nxt = all_open ? ST_CLOSE_WAIT : ST_OPEN_WAIT;
      end
      ST_CLOSE_WAIT: begin
        if (!all_open) begin
          tmr_load_o = 1'b1;
          nxt        = ST_CLOSE_DB;
        end
      end
      ST_CLOSE_DB: begin
        if (tmr_done_i) begin
          if (all_open) begin
            nxt = ST_CLOSE_WAIT;
          end else begin
            rows_nxt   = FIRST_ROW;
            ridx_nxt   = '0;
            tmr_load_o = 1'b1;
            tmr_val_o  = SETTLE_VAL;
            nxt        = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (tmr_done_i) begin
          if (!all_open) begin
            idx_nxt  = KP_IDX_W'(ridx_q) * KP_IDX_W'(KP_COLS) + KP_IDX_W'(lowest_low(cols_i));
            fire_nxt = 1'b1;
            rows_nxt = '0;
            nxt      = ST_EMIT;
          end else if (ridx_q == KP_RIDX_W'(KP_ROWS - 1)) begin
            rows_nxt = '0;
            nxt      = ST_CLOSE_WAIT;
          end else begin
            rows_nxt   = {rows_q[KP_ROWS-2:0], rows_q[KP_ROWS-1]};
            ridx_nxt   = ridx_q + 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = SETTLE_VAL;
          end
        end
      end
      ST_EMIT: begin
        rows_nxt = '0;
        nxt      = ST_OPEN_WAIT;
      end
      default: begin
        rows_nxt = '0;
        nxt      = ST_OPEN_WAIT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OPEN_WAIT;
      rows_q <= '0;
      ridx_q <= '0;
      idx_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      state  <= nxt;
      rows_q <= rows_nxt;
      ridx_q <= ridx_nxt;
      idx_q  <= idx_nxt;
      fire_q <= fire_nxt;
    end
  end

  assign rows_n_o = rows_q;
  assign fire_o   = fire_q;
  assign idx_o    = idx_q;

  AST_ROW_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (rows_q == '0) || ($countones(~rows_q) == 1)); // R4

  AST_SCAN_STARTS_ROW0: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CLOSE_DB && nxt == ST_SCAN) |=> (rows_q == FIRST_ROW)); // R4

  AST_EMIT_TO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT) |=> (state == ST_OPEN_WAIT && rows_q == '0)); // R8

endmodule

// File: rtl/kp_encoder.sv
module kp_encoder
  import kp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                fire_i,
  input  logic [KP_IDX_W-1:0] idx_i,
  output logic                valid_o,
  output logic [7:0]          code_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= 8'h00;
    end else begin
      valid_o <= fire_i;
      if (fire_i) code_o <= hex_char(idx_i);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R7

  AST_CODE_SET: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((code_o >= 8'h30 && code_o <= 8'h39) ||
                 (code_o >= 8'h41 && code_o <= 8'h46))); // R5

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] row_n_o,
  input  logic [3:0] col_n_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o
);

  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int TW     = $clog2(DEBOUNCE_CYCLES + SETTLE + 2);

  logic [KP_COLS-1:0]  cols_s;
  logic                tmr_load, tmr_done, fire;
  logic [TW-1:0]       tmr_val;
  logic [KP_IDX_W-1:0] idx;

  kp_sync #(.WIDTH(KP_COLS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(col_n_i), .q_o(cols_s)
  );

  kp_timer #(.WIDTH(TW)) timer_i (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  kp_fsm #(.DB_CYCLES(DEBOUNCE_CYCLES), .SETTLE_CYCLES(SETTLE), .TW(TW)) fsm_i (
    .clk(clk), .rst(rst), .cols_i(cols_s), .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .rows_n_o(row_n_o),
    .fire_o(fire), .idx_o(idx)
  );

  kp_encoder enc_i (
    .clk(clk), .rst(rst), .fire_i(fire), .idx_i(idx),
    .valid_o(key_valid_o), .code_o(key_code_o)
  );

endmodule

// File: tb/keypad_scanner_tb_top.sv
module keypad_scanner_tb_top;

  localparam int DB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_n;
  logic [3:0] col_n;
  logic       key_valid;
  logic [7:0] key_code;
  logic [15:0] keys = '0;

  int checks = 0;
  int errors = 0;
  int width_bad = 0;
  int row_bad = 0;
  logic prev_valid = 1'b0;

  localparam logic [7:0] EXP [16] = '{
    8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37,
    8'h38, 8'h39, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45, 8'h46};

  always #4 clk = ~clk;

  keypad_scanner #(.DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .row_n_o(row_n), .col_n_i(col_n),
    .key_valid_o(key_valid), .key_code_o(key_code)
  );

  // key matrix model with pull-ups
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (keys[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (key_valid && prev_valid) width_bad++;
      if (!(row_n == 4'b0000 || row_n == 4'b1110 || row_n == 4'b1101 ||
            row_n == 4'b1011 || row_n == 4'b0111)) row_bad++;
      prev_valid <= key_valid;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_code(input string tag, input logic [7:0] exp);
    int n = 0;
    while (!key_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " valid"}, 32'(key_valid), 32'd1);
    if (key_valid) check({tag, " code"}, 32'(key_code), 32'(exp));
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string tag, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (key_valid) seen++;
    end
    check({tag, " no code"}, 32'(seen), 32'd0);
  endtask

  task automatic let_go();
    keys = '0;
    repeat (3 * DB + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rows", 32'(row_n), 32'h0);
    check("R1 valid", 32'(key_valid), 32'h0);
    check("R1 code", 32'(key_code), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rows after", 32'(row_n), 32'h0);
    repeat (3 * DB) @(negedge clk);

    // R5: every key position
    for (int k = 0; k < 16; k++) begin
      keys = 16'(1) << k;
      expect_code("R5 key map", EXP[k]);
      let_go();
    end

    // R3: bounce shorter than debounce interval
    keys = 16'h0020;
    repeat (5) @(negedge clk);
    keys = '0;
    expect_quiet("R3 short bounce", 8 * DB);
    keys = 16'h0002;
    expect_code("R3 press after bounce", 8'h31);
    let_go();

    // R6: two columns in one row
    keys = 16'h00C0;
    expect_code("R6 cols 2+3", 8'h36);
    let_go();
    keys = 16'h0090;
    expect_code("R6 cols 0+3", 8'h34);
    let_go();

    // R10: two rows
    keys = 16'h0220;
    expect_code("R10 rows 1+2", 8'h35);
    let_go();
    keys = 16'h8001;
    expect_code("R10 rows 0+3", 8'h30);
    let_go();

    // R8: held key gives one code
    keys = 16'h0008;
    expect_code("R8 first", 8'h33);
    expect_quiet("R8 held", 12 * DB);
    let_go();

    // R9: key gone before scan finds it
    keys = 16'h0200;
    begin
      int n = 0;
      while (row_n != 4'b1110 && n < 2000) begin
        @(negedge clk);
        n++;
      end
    end
    keys = '0;
    expect_quiet("R9 empty scan", 6 * DB);
    check("R9 rows idle", 32'(row_n), 32'h0);
    keys = 16'h0400;
    expect_code("R9 next closure", 8'h41);
    let_go();

    // R2: key held through reset
    rst = 1'b1;
    keys = 16'h0020;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_quiet("R2 held from reset", 20 * DB);
    let_go();
    keys = 16'h0080;
    expect_code("R2 after release", 8'h37);
    let_go();

    check("R7 pulse width", 32'(width_bad), 32'd0);
    check("R4 row patterns", 32'(row_bad), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule